// File: doc/BRIEF.md
# Configuration Port FIFO Controller

This peripheral sits on a simple word-addressed register bus. It carries 32-bit configuration words from a host into a configuration sink, and it carries words read back from that sink to the host. The host fills a deep write FIFO and checks a vacancy count so that it never overfills it. It then sets a self-clearing control bit, and the block drains the FIFO over a valid/ready stream. For readback, the host loads a word count and sets a second self-clearing control bit. The block then asks the sink for that many words over a request/valid stream and stores them in a read FIFO. The host polls the FIFO occupancy and pops results by reading the data address.

Only one transfer runs at a time. A status register shows when the block is idle. Interrupt enable and status registers hold per-transfer completion flags for a separate interrupt block. Pushes beyond the write FIFO capacity are discarded and flagged in a sticky abort register.

Top module: `cfg_port_ctrl`

## Requirements
- R1: Registers sit at word indices 7 (global enable), 8 (interrupt flags), 10 (interrupt enables), 64 (write data), 65 (read data), 66 (readback count), 67 (control), 68 (status), 69 (vacancy), 70 (occupancy) and 71 (abort). Every other index, and the write-only index 64, reads zero. Writes to other indices change nothing.
- R2: Vacancy (69) reads WR_DEPTH minus the number of words held. After reset it reads WR_DEPTH.
- R3: A write to index 64 while the write FIFO is full is discarded and sets abort bit 0. That bit stays set until the host writes 1 to bit 0 of index 71.
- R4: Writing 1 to control bit 0 sends every word held in the write FIFO, in push order, one word per cycle in which cfg_wvalid and cfg_wready are both high. Control bit 0 reads 1 until the FIFO is empty and then reads 0 by itself.
- R5: Writing 1 to control bit 1 fetches exactly the number of words in index 66 (zero completes at once). Words move on cycles in which cfg_rreq and cfg_rvalid are both high. They are stored in arrival order, occupancy (70) counts them, and control bit 1 reads 1 until the fetch ends.
- R6: Reading index 65 returns the oldest read FIFO word and removes it. When the read FIFO is empty the read returns zero and the occupancy stays zero.
- R7: Status bit 0 reads 1 whenever no transfer runs. It reads 0 from the cycle after the accepted control write until the transfer ends. Status bit 2 is set when a readback ends and cleared when the next transfer starts.
- R8: Control writes made while a transfer runs are ignored. A control write with both bits set starts only the write transfer.
- R9: Index 7 keeps only bit 31 and index 10 keeps only bits 1:0. The end of a write transfer sets flag bit 0 of index 8 and the end of a readback sets flag bit 1. Writing 1 to a flag bit clears it.
- R10: cfg_rreq stays low while the read FIFO is full, so a readback longer than RD_DEPTH pauses until the host pops words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| host_wr | input | 1 | Register write strobe |
| host_rd | input | 1 | Register read strobe (pops the read FIFO at index 65) |
| host_addr | input | 7 | Register word index |
| host_wdata | input | 32 | Register write data |
| host_rdata | output | 32 | Register read data, combinational on host_addr |
| cfg_wvalid | output | 1 | Write-stream word valid |
| cfg_wready | input | 1 | Write-stream sink ready |
| cfg_wdata | output | 32 | Write-stream word |
| cfg_rreq | output | 1 | Read-stream word request |
| cfg_rvalid | input | 1 | Read-stream word valid |
| cfg_rdata | input | 32 | Read-stream word |

## Verification
A wrong FIFO pointer or count shows up at once in the vacancy or occupancy reads. It also shows up at the end of a drain or readback, where the words seen on the stream or popped by the host come out missing, repeated or out of order. A transfer-state fault shows within a cycle or two of the control write. Examples are a busy flag that never clears, which stalls the status poll, or a start accepted during a busy period, which produces extra stream traffic. The bench models the sink with random back-pressure and response delay. It fills the write FIFO to full and drives a readback longer than the read FIFO, and it compares every word against its own record.

// File: rtl/cfgp_pkg.sv
package cfgp_pkg;
  localparam int REG_GIE    = 7;
  localparam int REG_IFLAG  = 8;
  localparam int REG_IEN    = 10;
  localparam int REG_WDATA  = 64;
  localparam int REG_RDATA  = 65;
  localparam int REG_RBSIZE = 66;
  localparam int REG_CTRL   = 67;
  localparam int REG_STAT   = 68;
  localparam int REG_WVAC   = 69;
  localparam int REG_ROCC   = 70;
  localparam int REG_ABORT  = 71;

  typedef enum logic [1:0] {
    XF_IDLE  = 2'd0,
    XF_WRITE = 2'd1,
    XF_READ  = 2'd2
  } xfer_e;
endpackage

// File: rtl/cfgp_fifo.sv
module cfgp_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [W-1:0]  push_data,
  input  logic          pop,
  output logic [W-1:0]  head,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr_q, wptr_d, rptr_q, rptr_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          wr_en, rd_en;

  assign full  = (cnt_q == CW'(DEPTH));
  assign empty = (cnt_q == '0);
  assign wr_en = push && !full;
  assign rd_en = pop && !empty;
  assign head  = mem[rptr_q];
  assign count = cnt_q;

  always_comb begin
    wptr_d = wptr_q;
    rptr_d = rptr_q;
    cnt_d  = cnt_q;
    if (wr_en) wptr_d = (wptr_q == AW'(DEPTH - 1)) ? '0 : wptr_q + 1'b1;
    if (rd_en) rptr_d = (rptr_q == AW'(DEPTH - 1)) ? '0 : rptr_q + 1'b1;
    if (wr_en && !rd_en)      cnt_d = cnt_q + 1'b1;
    else if (rd_en && !wr_en) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      wptr_q <= wptr_d;
      rptr_q <= rptr_d;
      cnt_q  <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem[wptr_q] <= push_data;
  end
endmodule

// File: rtl/cfgp_xfer.sv
module cfgp_xfer
  import cfgp_pkg::*;
#(
  parameter int SIZE_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_wr,
  input  logic              start_rd,
  input  logic [SIZE_W-1:0] rb_size,
  input  logic              wf_empty,
  input  logic              rf_full,
  input  logic              cfg_wready,
  input  logic              cfg_rvalid,
  output logic              wr_busy,
  output logic              rd_busy,
  output logic              wf_pop,
  output logic              rf_push,
  output logic              cfg_wvalid,
  output logic              cfg_rreq,
  output logic              wr_done,
  output logic              rd_done,
  output logic              xfer_start
);
  xfer_e             st_q, st_d;
  logic [SIZE_W-1:0] rem_q, rem_d;

  assign wr_busy    = (st_q == XF_WRITE);
  assign rd_busy    = (st_q == XF_READ);
  assign cfg_wvalid = wr_busy && !wf_empty;
  assign wf_pop     = cfg_wvalid && cfg_wready;
  assign cfg_rreq   = rd_busy && (rem_q != '0) && !rf_full;
  assign rf_push    = cfg_rreq && cfg_rvalid;
  assign wr_done    = wr_busy && wf_empty;
  assign rd_done    = rd_busy && (rem_q == '0);
  assign xfer_start = (st_q == XF_IDLE) && (start_wr || start_rd);

  always_comb begin
    st_d  = st_q;
    rem_d = rem_q;
    case (st_q)
      XF_IDLE: begin
        if (start_wr) st_d = XF_WRITE;
        else if (start_rd) begin
          st_d  = XF_READ;
          rem_d = rb_size;
        end
      end
      XF_WRITE: if (wf_empty) st_d = XF_IDLE;
      XF_READ: begin
        if (rem_q == '0) st_d = XF_IDLE;
        else if (rf_push) rem_d = rem_q - 1'b1;
      end
      default: st_d = XF_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= XF_IDLE;
      rem_q <= '0;
    end else begin
      st_q  <= st_d;
      rem_q <= rem_d;
    end
  end
endmodule

// File: rtl/cfg_port_ctrl.sv
module cfg_port_ctrl
  import cfgp_pkg::*;
#(
  parameter int DW       = 32,
  parameter int AW       = 7,
  parameter int WR_DEPTH = 1024,
  parameter int RD_DEPTH = 64,
  parameter int SIZE_W   = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_wr,
  input  logic          host_rd,
  input  logic [AW-1:0] host_addr,
  input  logic [DW-1:0] host_wdata,
  output logic [DW-1:0] host_rdata,
  output logic          cfg_wvalid,
  input  logic          cfg_wready,
  output logic [DW-1:0] cfg_wdata,
  output logic          cfg_rreq,
  input  logic          cfg_rvalid,
  input  logic [DW-1:0] cfg_rdata
);
  localparam int WCW = $clog2(WR_DEPTH + 1);
  localparam int RCW = $clog2(RD_DEPTH + 1);

  logic [1:0]        rst_sync_q;
  logic              rst_n_i;
  logic              sel_gie, sel_iflag, sel_ien, sel_wdata, sel_rdata;
  logic              sel_size, sel_ctrl, sel_abort;
  logic              wf_push, wf_pop, wf_full, wf_empty;
  logic [WCW-1:0]    wf_count;
  logic              rf_push, rf_pop, rf_full, rf_empty;
  logic [RCW-1:0]    rf_count;
  logic [DW-1:0]     rf_head;
  logic              wr_busy, rd_busy, wr_done, rd_done, xfer_start;
  logic              gie_q, gie_d, ovf_q, ovf_d, rbdone_q, rbdone_d;
  logic [1:0]        ien_q, ien_d, iflag_q, iflag_d;
  logic [SIZE_W-1:0] size_q, size_d;
  logic [WCW-1:0]    vacancy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_i = rst_sync_q[1];

  assign sel_gie   = (host_addr == AW'(REG_GIE));
  assign sel_iflag = (host_addr == AW'(REG_IFLAG));
  assign sel_ien   = (host_addr == AW'(REG_IEN));
  assign sel_wdata = (host_addr == AW'(REG_WDATA));
  assign sel_rdata = (host_addr == AW'(REG_RDATA));
  assign sel_size  = (host_addr == AW'(REG_RBSIZE));
  assign sel_ctrl  = (host_addr == AW'(REG_CTRL));
  assign sel_abort = (host_addr == AW'(REG_ABORT));

  assign wf_push = host_wr && sel_wdata;
  assign rf_pop  = host_rd && sel_rdata;
  assign vacancy = WCW'(WR_DEPTH) - wf_count;

  cfgp_fifo #(.W(DW), .DEPTH(WR_DEPTH)) u_wfifo (
    .clk(clk), .rst_n(rst_n_i),
    .push(wf_push), .push_data(host_wdata),
    .pop(wf_pop), .head(cfg_wdata),
    .count(wf_count), .full(wf_full), .empty(wf_empty)
  );

  cfgp_fifo #(.W(DW), .DEPTH(RD_DEPTH)) u_rfifo (
    .clk(clk), .rst_n(rst_n_i),
    .push(rf_push), .push_data(cfg_rdata),
    .pop(rf_pop), .head(rf_head),
    .count(rf_count), .full(rf_full), .empty(rf_empty)
  );

  cfgp_xfer #(.SIZE_W(SIZE_W)) u_xfer (
    .clk(clk), .rst_n(rst_n_i),
    .start_wr(host_wr && sel_ctrl && host_wdata[0]),
    .start_rd(host_wr && sel_ctrl && host_wdata[1]),
    .rb_size(size_q), .wf_empty(wf_empty), .rf_full(rf_full),
    .cfg_wready(cfg_wready), .cfg_rvalid(cfg_rvalid),
    .wr_busy(wr_busy), .rd_busy(rd_busy),
    .wf_pop(wf_pop), .rf_push(rf_push),
    .cfg_wvalid(cfg_wvalid), .cfg_rreq(cfg_rreq),
    .wr_done(wr_done), .rd_done(rd_done), .xfer_start(xfer_start)
  );

  // next-state for host-visible registers
  always_comb begin
    gie_d    = gie_q;
    ien_d    = ien_q;
    size_d   = size_q;
    iflag_d  = iflag_q;
    ovf_d    = ovf_q;
    rbdone_d = rbdone_q;
    if (host_wr && sel_gie)   gie_d  = host_wdata[31];
    if (host_wr && sel_ien)   ien_d  = host_wdata[1:0];
    if (host_wr && sel_size)  size_d = host_wdata[SIZE_W-1:0];
    if (host_wr && sel_iflag) iflag_d = iflag_q & ~host_wdata[1:0];
    if (wr_done) iflag_d[0] = 1'b1;
    if (rd_done) iflag_d[1] = 1'b1;
    if (host_wr && sel_abort && host_wdata[0]) ovf_d = 1'b0;
    if (wf_push && wf_full) ovf_d = 1'b1;
    if (xfer_start) rbdone_d = 1'b0;
    if (rd_done)    rbdone_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      gie_q    <= 1'b0;
      ien_q    <= '0;
      size_q   <= '0;
      iflag_q  <= '0;
      ovf_q    <= 1'b0;
      rbdone_q <= 1'b0;
    end else begin
      gie_q    <= gie_d;
      ien_q    <= ien_d;
      size_q   <= size_d;
      iflag_q  <= iflag_d;
      ovf_q    <= ovf_d;
      rbdone_q <= rbdone_d;
    end
  end

  always_comb begin
    host_rdata = '0;
    case (int'(host_addr))
      REG_GIE:    host_rdata[31] = gie_q;
      REG_IFLAG:  host_rdata[1:0] = iflag_q;
      REG_IEN:    host_rdata[1:0] = ien_q;
      REG_RDATA:  host_rdata = rf_empty ? '0 : rf_head;
      REG_RBSIZE: host_rdata[SIZE_W-1:0] = size_q;
      REG_CTRL:   host_rdata[1:0] = {rd_busy, wr_busy};
      REG_STAT:   host_rdata[2:0] = {rbdone_q, 1'b0, !(wr_busy || rd_busy)};
      REG_WVAC:   host_rdata[WCW-1:0] = vacancy;
      REG_ROCC:   host_rdata[RCW-1:0] = rf_count;
      REG_ABORT:  host_rdata[0] = ovf_q;
      default:    host_rdata = '0;
    endcase
  end
endmodule

// File: rtl/cfg_port_ctrl_chk.sv
module cfg_port_ctrl_chk #(
  parameter int DW       = 32,
  parameter int AW       = 7,
  parameter int WR_DEPTH = 1024,
  localparam int WCW     = $clog2(WR_DEPTH + 1)
) (
  input logic           clk,
  input logic           rst_n_i,
  input logic           host_wr,
  input logic [AW-1:0]  host_addr,
  input logic [DW-1:0]  host_wdata,
  input logic           cfg_wvalid,
  input logic           cfg_wready,
  input logic [DW-1:0]  cfg_wdata,
  input logic           cfg_rreq,
  input logic           wr_busy,
  input logic           rd_busy,
  input logic [WCW-1:0] wf_count,
  input logic           rf_full,
  input logic           ovf_q
);
  AST_ONE_XFER: assert property (@(posedge clk) disable iff (!rst_n_i)
    !(wr_busy && rd_busy)); // R8
  AST_WVALID_IN_WRITE: assert property (@(posedge clk) disable iff (!rst_n_i)
    cfg_wvalid |-> wr_busy); // R4
  AST_WVALID_HOLD: assert property (@(posedge clk) disable iff (!rst_n_i)
    (cfg_wvalid && !cfg_wready) |=> (cfg_wvalid && $stable(cfg_wdata))); // R4
  AST_RREQ_ROOM: assert property (@(posedge clk) disable iff (!rst_n_i)
    cfg_rreq |-> (rd_busy && !rf_full)); // R10
  AST_FILL_BOUND: assert property (@(posedge clk) disable iff (!rst_n_i)
    wf_count <= WCW'(WR_DEPTH)); // R2
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n_i)
    (ovf_q && !(host_wr && host_addr == AW'(71) && host_wdata[0])) |=> ovf_q); // R3
endmodule

bind cfg_port_ctrl cfg_port_ctrl_chk #(.DW(DW), .AW(AW), .WR_DEPTH(WR_DEPTH)) u_chk (
  .clk(clk), .rst_n_i(rst_n_i), .host_wr(host_wr), .host_addr(host_addr),
  .host_wdata(host_wdata), .cfg_wvalid(cfg_wvalid), .cfg_wready(cfg_wready),
  .cfg_wdata(cfg_wdata), .cfg_rreq(cfg_rreq), .wr_busy(wr_busy),
  .rd_busy(rd_busy), .wf_count(wf_count), .rf_full(rf_full), .ovf_q(ovf_q)
);

// File: tb/cfg_port_ctrl_tb.sv
module cfg_port_ctrl_tb;
  localparam int CLK_P = 10;
  localparam int DEPTH = 1024;
  localparam int RDEP  = 64;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_wr = 1'b0, host_rd = 1'b0;
  logic [6:0]  host_addr = '0;
  logic [31:0] host_wdata = '0, host_rdata;
  logic        cfg_wvalid, cfg_wready = 1'b0, cfg_rreq, cfg_rvalid = 1'b0;
  logic [31:0] cfg_wdata, cfg_rdata = '0;

  int n_tests = 0, n_fail = 0;
  logic [31:0] sink_mem [4096];
  logic [31:0] exp_mem  [4096];
  int sink_n = 0, exp_n = 0, src_n = 0;
  bit wr_stall = 1'b0, rhs = 1'b0;

  cfg_port_ctrl u_dut (.*);

  always #(CLK_P/2) clk = ~clk;

  function automatic logic [31:0] gen(int k);
    return (32'(k) * 32'h9E37_79B1) ^ 32'hC3A5_0F1E;
  endfunction

  // sink / source models: capture at posedge, drive at negedge
  always @(posedge clk) begin
    if (cfg_wvalid && cfg_wready) begin sink_mem[sink_n] = cfg_wdata; sink_n++; end
    if (cfg_rreq && cfg_rvalid) begin src_n++; rhs = 1'b1; end
  end
  always @(negedge clk) begin
    cfg_wready = wr_stall ? 1'b0 : (($urandom % 4) != 0);
    if (rhs) begin cfg_rvalid = 1'b0; rhs = 1'b0; end
    else if (cfg_rreq && !cfg_rvalid && (($urandom % 3) == 0)) begin
      cfg_rvalid = 1'b1; cfg_rdata = gen(src_n);
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic bw(int a, logic [31:0] d);
    @(negedge clk); host_wr = 1'b1; host_addr = 7'(a); host_wdata = d;
    @(posedge clk); #1 host_wr = 1'b0;
  endtask

  task automatic br(int a, output logic [31:0] v);
    @(negedge clk); host_rd = 1'b1; host_addr = 7'(a);
    #1 v = host_rdata;
    @(posedge clk); #1 host_rd = 1'b0;
  endtask

  task automatic push(logic [31:0] d);
    bw(64, d); exp_mem[exp_n] = d; exp_n++;
  endtask

  task automatic wait_idle(string req);
    logic [31:0] v;
    for (int i = 0; i < 6000; i++) begin br(68, v); if (v[0]) break; end
    chk(req, {31'b0, v[0]}, 32'd1);
  endtask

  task automatic cmp_sink(string req);
    chk(req, 32'(sink_n), 32'(exp_n));
    for (int i = 0; i < exp_n && i < sink_n; i++)
      if (sink_mem[i] !== exp_mem[i]) begin chk(req, sink_mem[i], exp_mem[i]); break; end
  endtask

  initial begin
    #(CLK_P * 150000);
    n_fail++; n_tests++;
    $display("FAIL watchdog act=hung exp=done");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int n, base;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // reset state
    br(69, v); chk("R2 reset vacancy", v, DEPTH);
    br(70, v); chk("R5 reset occupancy", v, 0);
    br(68, v); chk("R7 reset status", v, 32'h1);
    br(67, v); chk("R4 reset ctrl", v, 0);
    br(71, v); chk("R3 reset abort", v, 0);
    br(5, v);  chk("R1 reserved read", v, 0);

    // reserved writes, interrupt registers
    bw(72, 32'hFFFF_FFFF); bw(3, 32'hFFFF_FFFF);
    br(72, v); chk("R1 reserved write", v, 0);
    br(64, v); chk("R1 write-data reads zero", v, 0);
    bw(7, 32'hFFFF_FFFF); br(7, v); chk("R9 gie bit", v, 32'h8000_0000);
    bw(10, 32'hFFFF_FFFF); br(10, v); chk("R9 ien bits", v, 32'h3);

    // random write drains
    for (int r = 0; r < 3; r++) begin
      n = 1 + ($urandom % 40);
      for (int i = 0; i < n; i++) push($urandom);
      br(69, v); chk("R2 vacancy after pushes", v, DEPTH - n);
      bw(67, 32'h1);
      br(68, v); chk("R7 busy after start", v[0], 0);
      br(67, v); chk("R4 ctrl bit0 while draining", v[0], 1);
      wait_idle("R7 write end");
      br(67, v); chk("R4 ctrl self-clear", v, 0);
      br(69, v); chk("R2 vacancy after drain", v, DEPTH);
      cmp_sink("R4 drain order");
      br(8, v); chk("R9 write flag", v[0], 1);
      bw(8, 32'h3); br(8, v); chk("R9 flag clear", v, 0);
    end

    // ignored starts while busy
    wr_stall = 1'b1;
    bw(66, 32'd5);
    for (int i = 0; i < 8; i++) push($urandom);
    bw(67, 32'h1);
    base = src_n;
    bw(67, 32'h2);
    br(67, v); chk("R8 read start ignored while busy", v, 32'h1);
    wr_stall = 1'b0;
    wait_idle("R8 end");
    br(70, v); chk("R8 no readback happened", v, 0);
    chk("R8 no source traffic", 32'(src_n - base), 0);
    cmp_sink("R8 single drain");

    // both bits: write wins
    for (int i = 0; i < 3; i++) push($urandom);
    bw(67, 32'h3);
    br(67, v); chk("R8 both bits write priority", v, 32'h1);
    wait_idle("R8 both end");
    br(70, v); chk("R8 both no readback", v, 0);
    cmp_sink("R8 both drain");

    // readbacks
    for (int r = 0; r < 2; r++) begin
      n = 1 + ($urandom % 20);
      base = src_n;
      bw(66, 32'(n));
      bw(67, 32'h2);
      br(68, v); chk("R7 busy during readback", v[0], 0);
      wait_idle("R5 readback end");
      br(70, v); chk("R5 occupancy", v, n);
      br(68, v); chk("R7 readback-done bit", v, 32'h5);
      for (int i = 0; i < n; i++) begin
        br(65, v); chk("R6 pop order", v, gen(base + i));
      end
      br(65, v); chk("R6 empty reads zero", v, 0);
      br(70, v); chk("R6 empty pop no change", v, 0);
      br(8, v); chk("R9 read flag", v[1], 1);
      bw(8, 32'h2);
    end

    // zero-size readback
    bw(66, 32'd0); bw(67, 32'h2);
    wait_idle("R5 zero size end");
    br(70, v); chk("R5 zero size occupancy", v, 0);

    // readback longer than read FIFO
    n = RDEP + 6; base = src_n;
    bw(66, 32'(n)); bw(67, 32'h2);
    for (int i = 0; i < 4000; i++) begin br(70, v); if (v == RDEP) break; end
    repeat (20) @(negedge clk);
    br(70, v); chk("R10 occupancy capped", v, RDEP);
    br(68, v); chk("R10 still busy", v[0], 0);
    chk("R10 source stalled", 32'(src_n - base), RDEP);
    for (int i = 0; i < n; i++) begin
      for (int k = 0; k < 200; k++) begin br(70, v); if (v != 0) break; end
      br(65, v); chk("R10 long readback data", v, gen(base + i));
    end
    wait_idle("R10 end");

    // overflow
    wr_stall = 1'b1;
    bw(67, 32'h0);
    for (int i = 0; i < DEPTH; i++) push($urandom);
    br(69, v); chk("R2 full vacancy", v, 0);
    bw(64, 32'hDEAD_BEEF);
    br(69, v); chk("R3 vacancy after drop", v, 0);
    br(71, v); chk("R3 overflow flag", v, 32'h1);
    bw(71, 32'h0); br(71, v); chk("R3 flag sticky", v, 32'h1);
    bw(71, 32'h1); br(71, v); chk("R3 flag clear", v, 0);
    wr_stall = 1'b0;
    bw(67, 32'h1);
    wait_idle("R3 drain end");
    cmp_sink("R3 drop not sent");

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule